// File: doc/BRIEF.md
# Multi-page MLC Gray-coded page read sequencer

This block reads one logical page out of a row of multi-level cells that hold two, three or four bits each under a Gray-coded page layout. A read starts with a one-cycle `start` pulse. The block then takes the bits-per-cell mode and the page number and works out which decision levels that page depends on. It issues one threshold compare per level through a request/acknowledge interface. A compare returns one bit per cell, and that bit is 1 when the cell sits above the requested level. The block folds all returned vectors into a per-cell parity. It then presents the page bits with a one-cycle valid strobe.

Page m of an M-bit cell needs 2^(m-1) compares. These are at the decision levels whose index is an odd multiple of 2^(M-m). Level k lies between state S(k-1) and state S(k). The table input carries the levels packed so that level k occupies slot k-1. A cell's page bit is the inverse of the parity of its compare results. An invalid mode/page pair produces a one-cycle error strobe and no compare.

The sequencer has five states. IDLE goes to ISSUE on `start` with a valid request, and goes to REJECT on `start` with an invalid one. ISSUE holds the request until acknowledge. It goes to GAP when compares remain and to DONE after the last compare. GAP returns to ISSUE. DONE and REJECT both return to IDLE.

Top module: `mlc_page_reader`

## Requirements
- R1: After reset `busy`, `cmp_req`, `page_valid` and `page_err` are 0, and `page_data` is all zeros.
- R2: A read of page m (1 ≤ m ≤ M) issues exactly 2^(m-1) compares.
- R3: The compares for page m of mode M use level indices k = 2^(M-m)·(2t+1), for t = 0, 1, … in ascending order. Index k means the table slot `lvl_table[(k-1)*LVL_W +: LVL_W]`.
- R4: For a cell in state s, with `cmp_hit` = 1 meaning above the level, the output bit of page m equals NOT bit (M-m) of s XOR (s>>1).
- R5: Only one compare is outstanding at a time. `cmp_req` and `cmp_level` stay steady until `cmp_ack`, and `cmp_req` is low in the cycle after an acknowledge.
- R6: `page_valid` is a one-cycle pulse after the last acknowledge, and `page_data` holds its value afterwards.
- R7: `bpc_mode` is the bits per cell in binary, and only the values 2..MAX_BPC are valid. A start with an invalid mode, with page 0, or with a page above the mode pulses `page_err` for one cycle. Such a start issues no compare, gives no `page_valid`, and leaves `page_data` unchanged.
- R8: A `start` while `busy` is 1 is ignored, and the running read completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a page read |
| bpc_mode | input | $clog2(MAX_BPC+1) | Bits per cell (2..MAX_BPC) |
| page_sel | input | $clog2(MAX_BPC+1) | Page number, 1-based |
| lvl_table | input | (2^MAX_BPC-1)·LVL_W | Decision levels, level k in slot k-1 |
| cmp_req | output | 1 | Compare request |
| cmp_level | output | LVL_W | Level for the requested compare |
| cmp_ack | input | 1 | Compare done, `cmp_hit` valid |
| cmp_hit | input | NCELL | Per-cell result, 1 = above level |
| busy | output | 1 | Read in progress |
| page_data | output | NCELL | Recovered page bits |
| page_valid | output | 1 | One-cycle strobe for `page_data` |
| page_err | output | 1 | One-cycle strobe for an invalid request |

## Verification
The main function is tried with every mode/page pair of the 2-, 3- and 4-bit modes. The cell states for each pair come from a multiply-add pattern, so that every state occurs in the row. The expected bits come from the Gray formula, while the compare model answers from modelled cell voltages. A wrong level choice or a wrong parity therefore appears as wrong bits. The compare count and the recorded level sequence separate a wrong stride from a wrong order. Acknowledge latencies of 0 to 2 cycles show whether the request is held and dropped correctly. Invalid requests and a second start during a busy read check that neither one disturbs compares or data.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GAP,
        ST_DONE,
        ST_REJECT
    } rd_state_t;

endpackage

// File: rtl/rdseq_level_pick.sv
module rdseq_level_pick #(
    parameter int MAX_BPC = 4
) (
    input  logic [$clog2(MAX_BPC+1)-1:0] mode_i,
    input  logic [$clog2(MAX_BPC+1)-1:0] page_i,
    input  logic [MAX_BPC-2:0]           step_i,
    output logic [MAX_BPC-1:0]           idx_o,
    output logic                         last_o
);
    localparam int KW = MAX_BPC;
    localparam int SW = MAX_BPC - 1;
    localparam int MW = $clog2(MAX_BPC+1);

    logic [MW-1:0] shift;
    logic [KW:0]   stride;
    logic [KW:0]   odd;
    logic [KW:0]   kval;
    logic [SW:0]   nstep;

    always_comb begin
        shift  = mode_i - page_i;
        stride = (KW+1)'(1) << shift;
        odd    = {1'b0, step_i, 1'b1};
        kval   = stride * odd;
        idx_o  = KW'(kval - (KW+1)'(1));
        nstep  = (SW+1)'(1) << (page_i - MW'(1));
        last_o = ({1'b0, step_i} == (nstep - (SW+1)'(1)));
    end

endmodule

// File: rtl/rdseq_level_mux.sv
module rdseq_level_mux #(
    parameter int MAX_BPC = 4,
    parameter int LVL_W   = 8
) (
    input  logic [((1<<MAX_BPC)-1)*LVL_W-1:0] table_i,
    input  logic [MAX_BPC-1:0]                idx_i,
    output logic [LVL_W-1:0]                  level_o
);
    localparam int NLVL = (1 << MAX_BPC) - 1;

    logic [LVL_W-1:0] slot [NLVL];

    genvar g;
    generate
        for (g = 0; g < NLVL; g++) begin : g_slot
            assign slot[g] = table_i[g*LVL_W +: LVL_W];
        end
    endgenerate

    always_comb begin
        level_o = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (idx_i == MAX_BPC'(i)) level_o = slot[i];
        end
    end

endmodule

// File: rtl/rdseq_parity_acc.sv
module rdseq_parity_acc #(
    parameter int NCELL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             fold_i,
    input  logic [NCELL-1:0] hit_i,
    output logic [NCELL-1:0] acc_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_o <= '0;
        else if (clr_i)  acc_o <= '0;
        else if (fold_i) acc_o <= acc_o ^ hit_i;
    end

    // R4
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0));

endmodule

// File: rtl/mlc_page_reader.sv
module mlc_page_reader
    import rdseq_pkg::*;
#(
    parameter int NCELL   = 16,
    parameter int LVL_W   = 8,
    parameter int MAX_BPC = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic [$clog2(MAX_BPC+1)-1:0]       bpc_mode,
    input  logic [$clog2(MAX_BPC+1)-1:0]       page_sel,
    input  logic [((1<<MAX_BPC)-1)*LVL_W-1:0]  lvl_table,
    output logic                               cmp_req,
    output logic [LVL_W-1:0]                   cmp_level,
    input  logic                               cmp_ack,
    input  logic [NCELL-1:0]                   cmp_hit,
    output logic                               busy,
    output logic [NCELL-1:0]                   page_data,
    output logic                               page_valid,
    output logic                               page_err
);
    localparam int MW = $clog2(MAX_BPC+1);
    localparam int SW = MAX_BPC - 1;
    localparam int KW = MAX_BPC;

    rd_state_t         state_q, state_d;
    logic [MW-1:0]     mode_q, page_q;
    logic [SW-1:0]     step_q;
    logic [KW-1:0]     lvl_idx;
    logic              last_step;
    logic              req_ok;
    logic              accept;
    logic              fold;
    logic [NCELL-1:0]  acc;
    logic [NCELL-1:0]  data_q;

    assign req_ok = (bpc_mode >= MW'(2)) && (bpc_mode <= MW'(MAX_BPC)) &&
                    (page_sel != '0) && (page_sel <= bpc_mode);
    assign accept = (state_q == ST_IDLE) && start && req_ok;
    assign fold   = (state_q == ST_ISSUE) && cmp_ack;

    rdseq_level_pick #(.MAX_BPC(MAX_BPC)) u_pick (
        .mode_i (mode_q),
        .page_i (page_q),
        .step_i (step_q),
        .idx_o  (lvl_idx),
        .last_o (last_step)
    );

    rdseq_level_mux #(.MAX_BPC(MAX_BPC), .LVL_W(LVL_W)) u_mux (
        .table_i (lvl_table),
        .idx_i   (lvl_idx),
        .level_o (cmp_level)
    );

    rdseq_parity_acc #(.NCELL(NCELL)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .fold_i (fold),
        .hit_i  (cmp_hit),
        .acc_o  (acc)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = req_ok ? ST_ISSUE : ST_REJECT;
            ST_ISSUE:  if (cmp_ack) state_d = last_step ? ST_DONE : ST_GAP;
            ST_GAP:    state_d = ST_ISSUE;
            ST_DONE:   state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            page_q <= '0;
            step_q <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                mode_q <= bpc_mode;
                page_q <= page_sel;
                step_q <= '0;
            end else if (fold) begin
                step_q <= step_q + SW'(1);
            end
            if (fold && last_step) data_q <= ~(acc ^ cmp_hit);
        end
    end

    always_comb begin
        cmp_req    = (state_q == ST_ISSUE);
        busy       = (state_q != ST_IDLE);
        page_valid = (state_q == ST_DONE);
        page_err   = (state_q == ST_REJECT);
        page_data  = data_q;
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && !cmp_ack) |=> cmp_req);
    // R5
    level_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && !cmp_ack) |=> $stable(cmp_level));
    // R5
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && cmp_ack) |=> !cmp_req);
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_valid |=> (!page_valid && $stable(page_data)));
    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |-> ($stable(page_data) && !cmp_req));
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && !cmp_ack && start) |=> cmp_req);

endmodule

// File: tb/mlc_page_reader_tb.sv
`timescale 1ns/1ps
module mlc_page_reader_tb;
    localparam int NC  = 16;
    localparam int LW  = 8;
    localparam int MB  = 4;
    localparam int NL  = (1 << MB) - 1;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [2:0] bpc_mode = 0, page_sel = 0;
    logic [NL*LW-1:0] lvl_table;
    logic cmp_req, cmp_ack = 0;
    logic [LW-1:0] cmp_level;
    logic [NC-1:0] cmp_hit = 0;
    logic busy, page_valid, page_err;
    logic [NC-1:0] page_data;

    int tests = 0, fails = 0;
    int ncmp = 0, lat = 0, wcnt = 0, r5_viol = 0;
    logic [LW-1:0] rec [16];
    logic [3:0] cell_s [NC];
    logic [LW-1:0] vt [NC];

    always #2 clk = ~clk;

    mlc_page_reader #(.NCELL(NC), .LVL_W(LW), .MAX_BPC(MB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bpc_mode(bpc_mode),
        .page_sel(page_sel), .lvl_table(lvl_table), .cmp_req(cmp_req),
        .cmp_level(cmp_level), .cmp_ack(cmp_ack), .cmp_hit(cmp_hit),
        .busy(busy), .page_data(page_data), .page_valid(page_valid),
        .page_err(page_err)
    );

    // stimulus: mode, page, mul, add (one hex digit each)
    localparam logic [15:0] VEC [11] = '{
        16'h2131, 16'h2215, 16'h3172, 16'h3237, 16'h3353, 16'h4193,
        16'h4256, 16'h437b, 16'h4475, 16'h3311, 16'h4411 };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        for (int k = 1; k <= NL; k++) lvl_table[(k-1)*LW +: LW] = LW'(16 * k);
    end

    // compare responder: cell above level -> hit
    initial begin
        forever begin
            @(negedge clk);
            if (cmp_ack) begin
                cmp_ack = 0;
                if (cmp_req) r5_viol++;
            end else if (cmp_req) begin
                if (wcnt >= lat) begin
                    for (int i = 0; i < NC; i++) cmp_hit[i] = (vt[i] > cmp_level);
                    if (ncmp < 16) rec[ncmp] = cmp_level;
                    ncmp++;
                    cmp_ack = 1;
                    wcnt = 0;
                end else wcnt++;
            end
        end
    end

    task automatic set_cells(input int m, input int mul, input int add);
        for (int i = 0; i < NC; i++) begin
            cell_s[i] = 4'((i * mul + add) & ((1 << m) - 1));
            vt[i] = LW'(16 * cell_s[i] + 8 + (i % 5) - 2);
        end
    endtask

    function automatic logic [NC-1:0] expect_page(input int m, input int p);
        logic [NC-1:0] r;
        for (int i = 0; i < NC; i++) begin
            logic [3:0] g;
            g = cell_s[i] ^ (cell_s[i] >> 1);
            r[i] = ~g[m - p];
        end
        return r;
    endfunction

    task automatic launch(input int m, input int p);
        @(negedge clk);
        bpc_mode = 3'(m); page_sel = 3'(p); ncmp = 0; wcnt = 0;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_end(output bit v, output bit e);
        v = 0; e = 0;
        for (int c = 0; c < 400 && !v && !e; c++) begin
            if (page_valid) v = 1;
            else if (page_err) e = 1;
            else @(negedge clk);
        end
    endtask

    task automatic check_read(input int m, input int p);
        bit v, e;
        logic [NC-1:0] d;
        int n;
        wait_end(v, e);
        chk(v && !e, "R6 valid seen", v, 1);
        d = expect_page(m, p);
        chk(page_data == d, "R4 page bits", page_data, d);
        n = 1 << (p - 1);
        chk(ncmp == n, "R2 compare count", ncmp, n);
        for (int t = 0; t < n && t < 16; t++) begin
            int k;
            k = (1 << (m - p)) * (2 * t + 1);
            chk(rec[t] == LW'(16 * k), "R3 level order", rec[t], 16 * k);
        end
        @(negedge clk);
        chk(!page_valid && page_data == d, "R6 pulse and hold", page_valid, 0);
    endtask

    task automatic bad_req(input int m, input int p);
        bit v, e;
        logic [NC-1:0] prev;
        prev = page_data;
        launch(m, p);
        wait_end(v, e);
        chk(e && !v, "R7 error strobe", e, 1);
        repeat (3) @(negedge clk);
        chk(ncmp == 0 && !busy, "R7 no compare", ncmp, 0);
        chk(page_data == prev, "R7 data kept", page_data, prev);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        set_cells(2, 1, 0);
        repeat (3) @(negedge clk);
        // R1
        chk(!busy && !cmp_req && !page_valid && !page_err && page_data == '0,
            "R1 reset state", {busy, cmp_req, page_valid, page_err}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !cmp_req, "R1 after release", busy, 0);

        foreach (VEC[j]) begin
            int m, p;
            m = int'(VEC[j][15:12]); p = int'(VEC[j][11:8]);
            set_cells(m, int'(VEC[j][7:4]), int'(VEC[j][3:0]));
            lat = j % 3;
            launch(m, p);
            check_read(m, p);
        end
        chk(r5_viol == 0, "R5 req drop after ack", r5_viol, 0);

        // R7: invalid combinations
        bad_req(2, 3);
        bad_req(5, 1);
        bad_req(3, 0);
        bad_req(1, 1);

        // R8: start during a busy read
        set_cells(3, 5, 2);
        lat = 2;
        launch(3, 3);
        repeat (3) @(negedge clk);
        bpc_mode = 3'd2; page_sel = 3'd1; start = 1;
        @(negedge clk);
        start = 0;
        bpc_mode = 3'd3; page_sel = 3'd3;
        check_read(3, 3);
        repeat (3) @(negedge clk);
        chk(!busy && ncmp == 4, "R8 start ignored", ncmp, 4);
        chk(r5_viol == 0, "R5 final", r5_viol, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule